// File: doc/BRIEF.md
# Coprocessor Control and I/O Register Block

This block is the byte-wide register file that sits in the main processor's I/O window. It holds a fixed region/version byte, a data and a control byte for each of three controller ports, a bus-request register and a reset register for a sound coprocessor. The two coprocessor registers drive the coprocessor's bus-request and reset lines, and a read of the bus-request register reports the coprocessor's bus-acknowledge input.

The same block gates main-processor accesses that fall in the coprocessor's memory window. Every such access costs one extra wait cycle. The access reaches the coprocessor memory port only if the bus is granted at that moment. Without a grant, a read returns all ones and a write is dropped. The main processor starts an access with a one-cycle `bus_sel` pulse and takes the result when `bus_ack` pulses.

Top module: `cpio_regs`

## Requirements
- R1: After reset, `cp_reset_o` is 1, `cp_busreq_o` is 0, every port data and control byte is 0, `bus_ack` is 0, `bus_rdata` is 0 and `cp_mem_en` is 0.
- R2: In the control window (`bus_addr[15]`=1), offset bits 12:0 below 0x100 select a register by offset[7:1]. Select 0 is the read-only version byte. Its bit 7 is EXPORT_REGION, its bit 6 is HZ50, its bit 5 is always 1, and bits 4:0 are 0. The default reads 0xA0. Writes to select 0 have no effect.
- R3: Selects 1 to 3 are the data bytes of ports 0 to 2, and selects 4 to 6 are their control bytes. These bytes read back as written and appear on `port_data_o[8*i+7:8*i]` and `port_ctrl_o[8*i+7:8*i]`. Below offset 0x100 a write takes `bus_wdata[7:0]`, and every read returns the byte in both halves of `bus_rdata`.
- R4: Selects 7 and above below 0x100, and every control offset other than 0x1100 and 0x1200 at or above 0x100, read as byte 0xFF. Writes to them change nothing.
- R5: A write to offset 0x1100 drives `cp_busreq_o` from bit 0 of the written byte.
- R6: A read of offset 0x1100 returns a byte whose bit 0 is the inverted `cp_busack_i` and whose bits 7:1 are `open_bus[15:9]`.
- R7: A write to offset 0x1200 with bit 0 = 1 releases the coprocessor (`cp_reset_o`=0), and bit 0 = 0 asserts reset. A read returns the inverted `cp_reset_o` in bit 0, with the other bits 0.
- R8: For word accesses at control offsets of 0x100 and above, a write takes `bus_wdata[15:8]`, and a read returns the byte in bits 15:8 with `open_bus[7:0]` in bits 7:0. A byte read returns the byte in both halves.
- R9: A control-window access is acknowledged one cycle after `bus_sel`. A coprocessor-window access (`bus_addr[15]`=0) is acknowledged two cycles after `bus_sel` because of one wait cycle.
- R10: `cp_mem_en` pulses only in the wait cycle, and only when `cp_busack_i` is 1. An ungranted read returns 0xFFFF. An ungranted write produces no strobe.
- R11: A coprocessor-window access drives `cp_mem_addr` = `bus_addr[14:0]`. A word write drives `bus_wdata[15:8]` and a byte write drives `bus_wdata[7:0]` on `cp_mem_wdata`. A granted read returns `cp_mem_rdata` in both halves.
- R12: A `bus_sel` pulse that arrives during the wait cycle of a coprocessor-window access is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | One-cycle access start |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_addr | input | 16 | Bit 15 selects the window; bits 14:0 give the offset |
| bus_wdata | input | 16 | Write data |
| open_bus | input | 16 | Last value seen on the main bus |
| bus_ack | output | 1 | Access completion pulse |
| bus_rdata | output | 16 | Read data, valid with `bus_ack` |
| port_data_o | output | 24 | Port data bytes, port 0 in the low byte |
| port_ctrl_o | output | 24 | Port control bytes, port 0 in the low byte |
| cp_busreq_o | output | 1 | Coprocessor bus request |
| cp_reset_o | output | 1 | Coprocessor reset, active high |
| cp_busack_i | input | 1 | Coprocessor bus grant |
| cp_mem_en | output | 1 | Coprocessor memory strobe |
| cp_mem_we | output | 1 | Coprocessor memory write |
| cp_mem_addr | output | 15 | Coprocessor memory address |
| cp_mem_wdata | output | 8 | Coprocessor memory write byte |
| cp_mem_rdata | input | 8 | Coprocessor memory read byte |

## Verification
The bench targets the byte-lane rules, which differ on each side of offset 0x100. A design that used the wrong lane for word writes would load the bus-request register from the low byte. A design that replicated word reads above 0x100 would lose the `open_bus` low byte. The bench also reads the bus-request register with the grant both high and low, using open-bus patterns whose bit 8 differs, so that a design that forgets to invert the grant, or that leaks bit 8 into the result, returns a wrong byte. It drops the grant during coprocessor-window accesses, where a design that ignores the grant would strobe memory or return real data. It also pulses `bus_sel` inside the wait cycle, where a design that accepts that pulse would change the bus-request line.

// File: rtl/cpio_regs.sv
module cpio_regs #(
  parameter bit EXPORT_REGION = 1'b1,
  parameter bit HZ50          = 1'b0,
  parameter int NPORTS        = 3,
  parameter int ADDR_W        = 16,
  parameter int OFS_W         = 13,
  parameter int CP_AW         = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic                  bus_word,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [15:0]           bus_wdata,
  input  logic [15:0]           open_bus,
  output logic                  bus_ack,
  output logic [15:0]           bus_rdata,
  output logic [NPORTS*8-1:0]   port_data_o,
  output logic [NPORTS*8-1:0]   port_ctrl_o,
  output logic                  cp_busreq_o,
  output logic                  cp_reset_o,
  input  logic                  cp_busack_i,
  output logic                  cp_mem_en,
  output logic                  cp_mem_we,
  output logic [CP_AW-1:0]      cp_mem_addr,
  output logic [7:0]            cp_mem_wdata,
  input  logic [7:0]            cp_mem_rdata
);

  localparam logic [OFS_W-1:0] LOW_LIMIT  = OFS_W'(16'h0100);
  localparam logic [OFS_W-1:0] BUSREQ_OFS = OFS_W'(16'h1100);
  localparam logic [OFS_W-1:0] RESET_OFS  = OFS_W'(16'h1200);
  localparam logic [7:0]       VERSION    = {EXPORT_REGION, HZ50, 1'b1, 5'b0};

  logic             busy, p_we;
  logic [CP_AW-1:0] p_addr;
  logic [7:0]       p_wdata;
  logic [7:0]       pdata [NPORTS];
  logic [7:0]       pctrl [NPORTS];
  logic [7:0]       ctl_byte;

  wire             start    = bus_sel & ~busy;
  wire             ctl_area = bus_addr[ADDR_W-1];
  wire [OFS_W-1:0] ofs      = bus_addr[OFS_W-1:0];
  wire             low_area = ofs < LOW_LIMIT;
  wire [6:0]       rsel     = ofs[7:1];
  wire             hi_lane  = bus_word & ~low_area;
  wire [7:0]       wbyte    = hi_lane ? bus_wdata[15:8] : bus_wdata[7:0];
  wire             ctl_wr   = start & ctl_area & bus_we;
  wire             low_wr   = ctl_wr & low_area;

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pdata[i] <= '0;
        pctrl[i] <= '0;
      end else begin
        if (low_wr && rsel == 7'(i + 1))          pdata[i] <= wbyte;
        if (low_wr && rsel == 7'(i + 1 + NPORTS)) pctrl[i] <= wbyte;
      end
    end
    assign port_data_o[8*i +: 8] = pdata[i];
    assign port_ctrl_o[8*i +: 8] = pctrl[i];
  end

  always_comb begin
    ctl_byte = 8'hFF;
    if (low_area) begin
      if (rsel == 7'd0) ctl_byte = VERSION;
      for (int i = 0; i < NPORTS; i++) begin
        if (rsel == 7'(i + 1))          ctl_byte = pdata[i];
        if (rsel == 7'(i + 1 + NPORTS)) ctl_byte = pctrl[i];
      end
    end else if (ofs == BUSREQ_OFS) begin
      ctl_byte = (open_bus[15:8] & 8'hFE) | {7'd0, ~cp_busack_i};
    end else if (ofs == RESET_OFS) begin
      ctl_byte = {7'd0, ~cp_reset_o};
    end
  end

  wire [15:0] ctl_rd = hi_lane ? {ctl_byte, open_bus[7:0]} : {ctl_byte, ctl_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_busreq_o <= 1'b0;
      cp_reset_o  <= 1'b1;
    end else if (ctl_wr) begin
      if (ofs == BUSREQ_OFS) cp_busreq_o <= wbyte[0];
      if (ofs == RESET_OFS)  cp_reset_o  <= ~wbyte[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      p_we    <= 1'b0;
      p_addr  <= '0;
      p_wdata <= '0;
    end else begin
      busy <= start & ~ctl_area;
      if (start && !ctl_area) begin
        p_we    <= bus_we;
        p_addr  <= bus_addr[CP_AW-1:0];
        p_wdata <= bus_word ? bus_wdata[15:8] : bus_wdata[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= (start & ctl_area) | busy;
      if (start && ctl_area && !bus_we)
        bus_rdata <= ctl_rd;
      else if (busy && !p_we)
        bus_rdata <= cp_busack_i ? {cp_mem_rdata, cp_mem_rdata} : 16'hFFFF;
    end
  end

  assign cp_mem_en    = busy & cp_busack_i;
  assign cp_mem_we    = cp_mem_en & p_we;
  assign cp_mem_addr  = p_addr;
  assign cp_mem_wdata = p_wdata;

  AST_CTRL_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ctl_area) |=> bus_ack); // R9
  AST_MEM_WAIT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ctl_area) |=> !bus_ack); // R9
  AST_MEM_ACK_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> bus_ack); // R9
  AST_UNGRANTED_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !p_we && !cp_busack_i) |=> bus_rdata == 16'hFFFF); // R10
  AST_BUSREQ_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ofs == BUSREQ_OFS) |=> cp_busreq_o == $past(wbyte[0])); // R5
  AST_RESET_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ofs == RESET_OFS) |=> cp_reset_o == !$past(wbyte[0])); // R7
  AST_SEL_IN_WAIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && busy) |=> ($stable(cp_busreq_o) && $stable(cp_reset_o))); // R12

endmodule

// File: tb/cpio_regs_tb.sv
module cpio_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, bus_word = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0, open_bus = '0;
  logic        bus_ack;
  logic [15:0] bus_rdata;
  logic [23:0] port_data_o, port_ctrl_o;
  logic        cp_busreq_o, cp_reset_o;
  logic        cp_busack_i = 1'b0;
  logic        cp_mem_en, cp_mem_we;
  logic [14:0] cp_mem_addr;
  logic [7:0]  cp_mem_wdata, cp_mem_rdata;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;
  assign cp_mem_rdata = cp_mem_addr[7:0] ^ 8'h5A;

  cpio_regs u_dut (
    .clk, .rst_n, .bus_sel, .bus_we, .bus_word, .bus_addr, .bus_wdata, .open_bus,
    .bus_ack, .bus_rdata, .port_data_o, .port_ctrl_o, .cp_busreq_o, .cp_reset_o,
    .cp_busack_i, .cp_mem_en, .cp_mem_we, .cp_mem_addr, .cp_mem_wdata, .cp_mem_rdata
  );

  // {req[4], we, word, addr[16], wdata[16], open_bus[16], grant, expected[16]}
  localparam int NV = 30;
  localparam logic [70:0] VEC [NV] = '{
    {4'd2, 1'b0,1'b0,16'h8000,16'h0000,16'h0000,1'b0,16'hA0A0},  // R2
    {4'd2, 1'b1,1'b0,16'h8001,16'h00FF,16'h0000,1'b0,16'h0000},  // R2
    {4'd2, 1'b0,1'b0,16'h8001,16'h0000,16'h0000,1'b0,16'hA0A0},  // R2
    {4'd3, 1'b1,1'b0,16'h8003,16'h0012,16'h0000,1'b0,16'h0000},  // R3
    {4'd3, 1'b1,1'b0,16'h8005,16'h0034,16'h0000,1'b0,16'h0000},  // R3
    {4'd3, 1'b1,1'b0,16'h8007,16'h0056,16'h0000,1'b0,16'h0000},  // R3
    {4'd3, 1'b1,1'b0,16'h8009,16'h000F,16'h0000,1'b0,16'h0000},  // R3
    {4'd3, 1'b1,1'b0,16'h800B,16'h003C,16'h0000,1'b0,16'h0000},  // R3
    {4'd3, 1'b1,1'b0,16'h800D,16'h007E,16'h0000,1'b0,16'h0000},  // R3
    {4'd3, 1'b0,1'b1,16'h8002,16'h0000,16'hFFFF,1'b0,16'h1212},  // R3
    {4'd3, 1'b0,1'b1,16'h8006,16'h0000,16'hFFFF,1'b0,16'h5656},  // R3
    {4'd3, 1'b0,1'b0,16'h800C,16'h0000,16'h0000,1'b0,16'h7E7E},  // R3
    {4'd3, 1'b1,1'b1,16'h8004,16'hAB99,16'h0000,1'b0,16'h0000},  // R3
    {4'd3, 1'b0,1'b0,16'h8005,16'h0000,16'h0000,1'b0,16'h9999},  // R3
    {4'd4, 1'b1,1'b0,16'h800E,16'h0011,16'h0000,1'b0,16'h0000},  // R4
    {4'd4, 1'b0,1'b0,16'h800E,16'h0000,16'h0000,1'b0,16'hFFFF},  // R4
    {4'd4, 1'b0,1'b0,16'h80FE,16'h0000,16'h0000,1'b0,16'hFFFF},  // R4
    {4'd4, 1'b1,1'b0,16'h8101,16'h0000,16'h0000,1'b0,16'h0000},  // R4
    {4'd8, 1'b0,1'b1,16'h8300,16'h0000,16'h1234,1'b0,16'hFF34},  // R8
    {4'd5, 1'b1,1'b0,16'h9100,16'h0001,16'h0000,1'b0,16'h0000},  // R5
    {4'd6, 1'b0,1'b0,16'h9100,16'h0000,16'hA500,1'b1,16'hA4A4},  // R6
    {4'd6, 1'b0,1'b1,16'h9100,16'h0000,16'h5A3C,1'b0,16'h5B3C},  // R6
    {4'd8, 1'b1,1'b1,16'h9100,16'h0001,16'h0000,1'b0,16'h0000},  // R8
    {4'd8, 1'b0,1'b1,16'h9200,16'h0000,16'h00C3,1'b0,16'h00C3},  // R8
    {4'd7, 1'b1,1'b0,16'h9200,16'h0001,16'h0000,1'b0,16'h0000},  // R7
    {4'd7, 1'b0,1'b0,16'h9200,16'h0000,16'h0000,1'b0,16'h0101},  // R7
    {4'd11,1'b0,1'b0,16'h0010,16'h0000,16'h0000,1'b1,16'h4A4A},  // R11
    {4'd10,1'b0,1'b0,16'h0010,16'h0000,16'h0000,1'b0,16'hFFFF},  // R10
    {4'd10,1'b1,1'b0,16'h0020,16'h0077,16'h0000,1'b0,16'h0000},  // R10
    {4'd11,1'b0,1'b1,16'h7FFF,16'h0000,16'h0000,1'b1,16'hA5A5}   // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic word, input logic [15:0] addr,
                        input logic [15:0] wdata, output logic [15:0] rdata,
                        output int lat, output logic en_seen, output logic we_seen,
                        output logic [14:0] a_seen, output logic [7:0] d_seen);
    bus_we = we; bus_word = word; bus_addr = addr; bus_wdata = wdata; bus_sel = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0;
    lat = 1; en_seen = 1'b0; we_seen = 1'b0; a_seen = '0; d_seen = '0;
    while (!bus_ack && lat < 5) begin
      if (cp_mem_en) begin
        en_seen = 1'b1; we_seen = cp_mem_we; a_seen = cp_mem_addr; d_seen = cp_mem_wdata;
      end
      @(negedge clk);
      lat++;
    end
    rdata = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int          lat;
    logic        en, wes;
    logic [14:0] a;
    logic [7:0]  d;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busreq", 32'(cp_busreq_o), 32'd0);
    chk("R1 reset", 32'(cp_reset_o), 32'd1);
    chk("R1 ports", {8'd0, port_data_o}, {8'd0, port_ctrl_o});
    chk("R1 ack/rdata", {15'd0, bus_ack, bus_rdata}, 32'd0);
    chk("R1 mem_en", 32'(cp_mem_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [70:0] v;
      v = VEC[i];
      open_bus = v[32:17]; cp_busack_i = v[16];
      access(v[66], v[65], v[64:49], v[48:33], rd, lat, en, wes, a, d);
      chk($sformatf("R%0d vec %0d latency (R9)", v[70:67], i), 32'(lat), v[64] ? 32'd1 : 32'd2);
      if (!v[66])
        chk($sformatf("R%0d vec %0d rdata", v[70:67], i), 32'(rd), 32'(v[15:0]));
      if (!v[64])
        chk($sformatf("R%0d vec %0d mem strobe (R10)", v[70:67], i), 32'(en), 32'(v[16]));
      @(negedge clk);
    end

    // R3 R4 port outputs reflect writes, unmapped writes left them alone
    chk("R3 port data", 32'(port_data_o), 32'h569912);
    chk("R3 port ctrl", 32'(port_ctrl_o), 32'h7E3C0F);
    chk("R8 busreq from high byte", 32'(cp_busreq_o), 32'd0);
    chk("R7 reset released", 32'(cp_reset_o), 32'd0);

    // R11 word write uses high byte and bits 14:0 as address
    cp_busack_i = 1'b1;
    access(1'b1, 1'b1, 16'h4021, 16'hC711, rd, lat, en, wes, a, d);
    chk("R11 word write", {15'd0, en, wes, a}, {15'd0, 1'b1, 1'b1, 15'h4021});
    chk("R11 word write data", 32'(d), 32'hC7);
    @(negedge clk);
    access(1'b1, 1'b0, 16'h0033, 16'h2288, rd, lat, en, wes, a, d);
    chk("R11 byte write data", {16'd0, a, 1'b0, d[7:0]} >> 0, {16'd0, 15'h0033, 1'b0, 8'h88});

    // R5 byte writes set and clear bus request
    @(negedge clk);
    access(1'b1, 1'b0, 16'h9100, 16'h0001, rd, lat, en, wes, a, d);
    chk("R5 busreq set", 32'(cp_busreq_o), 32'd1);
    access(1'b1, 1'b0, 16'h9100, 16'h0000, rd, lat, en, wes, a, d);
    chk("R5 busreq clear", 32'(cp_busreq_o), 32'd0);

    // R12 sel in wait cycle ignored
    bus_we = 1'b0; bus_word = 1'b0; bus_addr = 16'h0005; bus_sel = 1'b1;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 16'h9100; bus_wdata = 16'h0001;
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R12 ack after wait", 32'(bus_ack), 32'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R12 busreq unchanged", 32'(cp_busreq_o), 32'd0);
    chk("R12 no extra ack", 32'(bus_ack), 32'd0);

    // R1 reset re-applied mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reapply reset", {cp_reset_o, cp_busreq_o, port_data_o}, {1'b1, 1'b0, 24'd0});
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule